// File: doc/BRIEF.md
# Serial Clock-Chip Register Shadow Programmer

This block sits on a host register bus and holds readable copies of the write-only configuration registers of an external clock jitter-cleaner chip. The host writes a 32-bit word into one of eight shadow slots. The block keeps the word, forces the slot's address nibble into bits 3:0, and shifts the word out to the chip over a three-wire microwire-style link. That link has a serial clock, a data line and a latch enable.

A control/status word at bus address 0 carries several fields. Bit 0 is a busy flag, which tells the host when it may write the next slot. Bit 1 is a synchronized copy of the chip's lock-detect pin. Bit 4 is a global output enable, and bit 6 is a sticky error flag. Writing 1 to bit 5 produces a low-going sync pulse that realigns the chip's outputs.

The shadows are cleared only by the power-up reset or by the self-clearing reset bit in slot R0. The ordinary board soft reset does not touch them.

Top module: `clkchip_shadow_prog`

## Requirements
- R1: Bus addresses 1 to 8 select the shadow slots R0, R1, R3, R4, R11, R13, R14 and R15. Their fixed address codes in bits 3:0 are 0000, 0001, 0011, 0100, 1011, 1101, 1110 and 1111. A read returns the stored bits 31:4 with that code below them, and the power-up value is the code alone.
- R2: Each accepted shadow write sends {data[31:4], code} MSB first as 32 rising edges of uw_clk, with uw_data stable while uw_clk is high. After the last falling edge, uw_le is high for exactly one bus cycle. Each half period of uw_clk lasts DIV bus cycles.
- R3: Status bit 0 reads 1 from the cycle after an accepted shadow write, for exactly 64*DIV+1 cycles, and reads 0 otherwise. uw_clk and uw_le stay low while idle.
- R4: A shadow write whose byte enables are not 4'b1111 is ignored: nothing is stored and nothing is sent. A status write takes effect whenever byte lane 0 is enabled.
- R5: An accepted write to R0 with bit 31 set is still sent with bit 31 set. Every shadow then returns to its power-up value, so R0 bit 31 reads 0 afterwards.
- R6: The soft_rst input clears the output enable and the error flag and leaves every shadow unchanged.
- R7: Status bit 1 follows lock_in through a two-flop synchronizer (1 means locked). Status bit 4 is read/write, drives out_en, and is 0 after power-up.
- R8: Writing 1 to status bit 5 drives sync_n low for exactly SYNC_LEN (8) cycles, starting after the write. Bit 5 reads 0.
- R9: A full write to R15 is rejected if its N divider in bits 25:8 is 0 or its VCO divider in bits 29:26 lies outside 2 to 8. A rejected write stores nothing, sends nothing and sets status bit 6.
- R10: A full shadow write while busy is ignored and sets status bit 6. Bit 6 stays set until the host writes 1 to it or soft_rst is applied.
- R11: Unused status bits (bit 5 and bits 31:7) and addresses 9 to 15 read 0. Writes to addresses 9 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-up reset, active low, clears everything |
| soft_rst | input | 1 | Board soft reset, clears control bits only |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 4 | Word address: 0 status, 1 to 8 shadows |
| be | input | 4 | Byte enables of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| lock_in | input | 1 | Lock-detect pin from the clock chip |
| uw_clk | output | 1 | Serial clock to the chip |
| uw_data | output | 1 | Serial data to the chip |
| uw_le | output | 1 | Serial latch enable to the chip |
| sync_n | output | 1 | Output sync pulse, active low |
| out_en | output | 1 | Global clock output enable |

## Verification
The hardest case to reach from the ports is a write that arrives while a frame is still shifting out. That write must leave both the stored slot and the outgoing frame untouched and must raise only the sticky error flag. The bench reaches it by issuing a second full write a few cycles into a transfer. It then checks three things: that exactly one frame came out, that the second slot still reads its old value, and that the flag survives until it is cleared.

The self-clearing R0 reset is also covered, with the shadows preloaded to random values first. The R15 limit values 1, 2, 8 and 9 are driven on purpose.

// File: rtl/clkchip_shadow_prog.sv
`timescale 1ns/1ps
module clkchip_shadow_prog #(
  parameter int DIV      = 2,
  parameter int SYNC_LEN = 8
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        soft_rst,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        lock_in,
  output logic        uw_clk,
  output logic        uw_data,
  output logic        uw_le,
  output logic        sync_n,
  output logic        out_en
);
  localparam int NREG   = 8;
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int SYNC_W = $clog2(SYNC_LEN + 1);
  localparam logic [3:0] CODE [NREG] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd11, 4'd13, 4'd14, 4'd15};

  logic [27:0]       shadow [NREG];
  logic              busy;
  logic [DIV_W-1:0]  half;
  logic [4:0]        bitn;
  logic [31:0]       sreg;
  logic [1:0]        lock_sync;
  logic              err;
  logic [SYNC_W-1:0] sync_cnt;

  logic [2:0] idx;
  logic [3:0] vco;
  logic       sh_hit, full, r15_bad, accept, reject, st_wr;

  assign idx     = 3'(addr - 4'd1);
  assign vco     = wdata[29:26];
  assign sh_hit  = wr_en && (addr >= 4'd1) && (addr <= 4'd8);
  assign full    = (be == 4'hF);
  assign r15_bad = (idx == 3'd7) && ((wdata[25:8] == 18'd0) || (vco < 4'd2) || (vco > 4'd8));
  assign accept  = sh_hit && full && !busy && !r15_bad;
  assign reject  = sh_hit && full && (busy || r15_bad);
  assign st_wr   = wr_en && (addr == 4'd0) && be[0];
  assign uw_data = sreg[31];
  assign sync_n  = (sync_cnt == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (accept) begin
      if (idx == 3'd0 && wdata[31]) begin
        for (int i = 0; i < NREG; i++) shadow[i] <= '0;
      end else begin
        shadow[idx] <= wdata[31:4];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy   <= 1'b0;
      uw_le  <= 1'b0;
      uw_clk <= 1'b0;
      half   <= '0;
      bitn   <= '0;
      sreg   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      uw_clk <= 1'b0;
      half   <= '0;
      bitn   <= '0;
      sreg   <= {wdata[31:4], CODE[idx]};
    end else if (uw_le) begin
      uw_le <= 1'b0;
      busy  <= 1'b0;
    end else if (busy) begin
      if (half == DIV_W'(DIV - 1)) begin
        half   <= '0;
        uw_clk <= ~uw_clk;
        if (uw_clk) begin
          if (bitn == 5'd31) begin
            uw_le <= 1'b1;
          end else begin
            bitn <= bitn + 5'd1;
            sreg <= {sreg[30:0], 1'b0};
          end
        end
      end else begin
        half <= half + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      out_en    <= 1'b0;
      err       <= 1'b0;
      sync_cnt  <= '0;
      lock_sync <= '0;
    end else begin
      lock_sync <= {lock_sync[0], lock_in};
      if (st_wr && wdata[5])      sync_cnt <= SYNC_W'(SYNC_LEN);
      else if (sync_cnt != '0)    sync_cnt <= sync_cnt - SYNC_W'(1);
      if (soft_rst) begin
        out_en <= 1'b0;
        err    <= 1'b0;
      end else begin
        if (st_wr) out_en <= wdata[4];
        if (reject)                 err <= 1'b1;
        else if (st_wr && wdata[6]) err <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 4'd0)
      rdata = {25'd0, err, 1'b0, out_en, 2'b00, lock_sync[1], busy};
    else if (addr <= 4'd8)
      rdata = {shadow[idx], CODE[idx]};
  end

  // R2
  le_one_chk: assert property (@(posedge clk) disable iff (!por_n) uw_le |=> !uw_le);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (uw_clk && $past(uw_clk)) |-> $stable(uw_data));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!por_n) !busy |-> (!uw_clk && !uw_le));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!por_n) $rose(busy) |-> $past(wr_en));
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!por_n) $rose(err) |-> $past(wr_en));
  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!por_n) $fell(sync_n) |=> !sync_n);
endmodule

// File: tb/clkchip_shadow_prog_tb.sv
`timescale 1ns/1ps
module clkchip_shadow_prog_tb;
  localparam int DIV = 2;
  localparam int SYNC_LEN = 8;

  logic clk = 1'b0, por_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0, lock_in = 1'b0;
  logic [3:0] addr = 4'd0, be = 4'd0;
  logic [31:0] wdata = '0, rdata;
  logic uw_clk, uw_data, uw_le, sync_n, out_en;

  clkchip_shadow_prog #(.DIV(DIV), .SYNC_LEN(SYNC_LEN)) u_dut (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .uw_clk(uw_clk), .uw_data(uw_data),
    .uw_le(uw_le), .sync_n(sync_n), .out_en(out_en));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, frames = 0, mon_cnt = 0, last_cnt = 0;
  logic [31:0] mon_bits = '0, last_frame = '0;
  logic [27:0] model [8];
  bit done = 0;

  always @(posedge uw_clk or posedge uw_le) begin
    if (uw_le) begin
      frames = frames + 1;
      last_frame = mon_bits;
      last_cnt = mon_cnt;
      mon_cnt = 0;
    end else begin
      mon_bits = {mon_bits[30:0], uw_data};
      mon_cnt = mon_cnt + 1;
    end
  end

  function automatic logic [3:0] code_of(input int i);
    case (i)
      0: return 4'd0;  1: return 4'd1;  2: return 4'd3;  3: return 4'd4;
      4: return 4'd11; 5: return 4'd13; 6: return 4'd14; default: return 4'd15;
    endcase
  endfunction

  function automatic bit r15_ok(input logic [31:0] d);
    return (d[25:8] != 18'd0) && (d[29:26] >= 4'd2) && (d[29:26] <= 4'd8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'd0; be = 4'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 4'd0; #1;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    addr = 4'd0; #1;
    while (rdata[0]) begin
      cyc++;
      @(negedge clk); #1;
    end
  endtask

  task automatic shadow_wr(input int i, input logic [31:0] d, input string req);
    int cyc, f0;
    logic [31:0] r;
    f0 = frames;
    bus_wr(4'(i + 1), 4'hF, d);
    wait_idle(cyc);
    chk({req, " R3 busy length"}, cyc, 64 * DIV + 1);
    chk({req, " R2 one frame"}, frames - f0, 1);
    chk({req, " R2 bit count"}, last_cnt, 32);
    chk({req, " R2 frame word"}, last_frame, {d[31:4], code_of(i)});
    if (i == 0 && d[31]) begin
      for (int k = 0; k < 8; k++) model[k] = '0;
    end else begin
      model[i] = d[31:4];
    end
    rd(4'(i + 1), r);
    chk({req, " R1 readback"}, r, {model[i], code_of(i)});
  endtask

  task automatic check_all(input string req);
    logic [31:0] r;
    for (int k = 0; k < 8; k++) begin
      rd(4'(k + 1), r);
      chk(req, r, {model[k], code_of(k)});
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d;
    int cyc, f0, idx;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 R7 R11: power-up state
    check_all("R1 reset value");
    rd(4'd0, r); chk("R7 status reset", r, 32'd0);
    chk("R8 sync_n idle", {31'd0, sync_n}, 32'd1);
    chk("R3 serial idle", {30'd0, uw_clk, uw_le}, 32'd0);
    chk("R7 out_en reset", {31'd0, out_en}, 32'd0);

    // R2: directed frame
    shadow_wr(6, 32'hDEADBEEF, "R2 directed");
    shadow_wr(1, 32'h0000_0000, "R2 zero word");

    // R1 R2 R3: random traffic
    for (int n = 0; n < 24; n++) begin
      idx = int'($urandom % 8);
      d = $urandom;
      if (idx == 0) d[31] = 1'b0;
      if (idx == 7) begin
        d[29:26] = 4'(2 + ($urandom % 7));
        d[8] = 1'b1;
      end
      shadow_wr(idx, d, "R1 random");
    end

    // R4: partial shadow write ignored
    f0 = frames;
    bus_wr(4'd3, 4'h3, 32'h1234_5678);
    @(negedge clk);
    rd(4'd0, r); chk("R4 no busy", r[0], 1'b0);
    chk("R4 no frame", frames - f0, 0);
    check_all("R4 shadows unchanged");

    // R10: write while busy
    f0 = frames;
    bus_wr(4'd2, 4'hF, 32'hA5A5_A5A0);
    repeat (5) @(negedge clk);
    bus_wr(4'd4, 4'hF, 32'h5A5A_5A50);
    wait_idle(cyc);
    model[1] = 28'hA5A5_A5A;
    chk("R10 single frame", frames - f0, 1);
    check_all("R10 busy write ignored");
    rd(4'd0, r); chk("R10 err set", r & 32'h40, 32'h40);
    repeat (3) @(negedge clk);
    rd(4'd0, r); chk("R10 err sticky", r & 32'h40, 32'h40);
    bus_wr(4'd0, 4'h1, 32'h40);
    rd(4'd0, r); chk("R10 err cleared", r & 32'h40, 32'h0);

    // R9: R15 limits
    f0 = frames;
    bus_wr(4'd8, 4'hF, {2'b00, 4'd4, 18'd0, 8'h00});
    @(negedge clk);
    rd(4'd0, r); chk("R9 N zero err", r & 32'h41, 32'h40);
    bus_wr(4'd0, 4'h1, 32'h40);
    bus_wr(4'd8, 4'hF, {2'b00, 4'd9, 18'd5, 8'h00});
    @(negedge clk);
    rd(4'd0, r); chk("R9 vco 9 err", r & 32'h41, 32'h40);
    bus_wr(4'd0, 4'h1, 32'h40);
    bus_wr(4'd8, 4'hF, {2'b00, 4'd1, 18'd5, 8'h00});
    @(negedge clk);
    rd(4'd0, r); chk("R9 vco 1 err", r & 32'h41, 32'h40);
    bus_wr(4'd0, 4'h1, 32'h40);
    chk("R9 no frames", frames - f0, 0);
    check_all("R9 R15 unchanged");
    shadow_wr(7, {2'b01, 4'd8, 18'd1, 8'h3C}, "R9 vco 8 ok");
    shadow_wr(7, {2'b10, 4'd2, 18'h3FFFF, 8'h00}, "R9 vco 2 ok");
    rd(4'd0, r); chk("R9 no err on valid", r & 32'h40, 32'h0);

    // R5: self-clearing reset in R0
    shadow_wr(0, 32'h8765_4321, "R5 reset write");
    check_all("R5 all defaults");
    rd(4'd1, r); chk("R5 bit31 clear", r[31], 1'b0);

    // R6: soft reset
    shadow_wr(3, 32'hCAFE_F00D, "R6 preload");
    bus_wr(4'd0, 4'h1, 32'h10);
    bus_wr(4'd2, 4'hF, 32'h1111_1110);
    bus_wr(4'd5, 4'hF, 32'h2222_2220);
    wait_idle(cyc);
    model[1] = 28'h1111_111;
    rd(4'd0, r); chk("R6 pre state", r & 32'h50, 32'h50);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(4'd0, r); chk("R6 control cleared", r & 32'h50, 32'h0);
    chk("R6 out_en low", {31'd0, out_en}, 32'd0);
    check_all("R6 shadows kept");

    // R7: lock and output enable
    lock_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd0, r); chk("R7 lock high", r[1], 1'b1);
    lock_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd0, r); chk("R7 lock low", r[1], 1'b0);
    bus_wr(4'd0, 4'h1, 32'h10);
    rd(4'd0, r); chk("R7 out_en bit", r[4], 1'b1);
    chk("R7 out_en pin", {31'd0, out_en}, 32'd1);
    bus_wr(4'd0, 4'h2, 32'h0);
    chk("R7 lane1 no effect", {31'd0, out_en}, 32'd1);

    // R8: sync pulse
    bus_wr(4'd0, 4'h1, 32'h30);
    rd(4'd0, r); chk("R8 bit5 reads 0", r[5], 1'b0);
    cyc = 0;
    while (!sync_n && cyc < 100) begin cyc++; @(negedge clk); end
    chk("R8 sync length", cyc, SYNC_LEN);

    // R11: unused bits and unmapped addresses
    f0 = frames;
    bus_wr(4'd12, 4'hF, 32'hFFFF_FFFF);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), r); chk("R11 unmapped reads 0", r, 32'd0);
    end
    chk("R11 unmapped no frame", frames - f0, 0);
    check_all("R11 shadows kept");
    bus_wr(4'd0, 4'hF, 32'hFFFF_FFFF);
    rd(4'd0, r); chk("R11 status mask", r, 32'h10);
    repeat (12) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule